// File: doc/BRIEF.md
# ADC conversion timing sequencer

This block paces one conversion of a successive-approximation ADC front end. A single start pulse launches a run. The run uses a settings word made of a clock divider code, a long-sample extension code, an averaging enable and count code, and a resolution code. The block derives a conversion tick from the system clock and spends a fixed startup window of ticks. It then repeats a sample phase and a convert phase once per averaged sample. The sample phase drives a sample-enable strobe to an external converter stub, and the convert phase drives a convert-enable strobe.

At the end of each convert window the raw result offered by the stub is added into an accumulator. After the last sample the block divides the sum by the sample count and cuts it to the chosen resolution. It then presents the result together with a one-cycle done pulse.

The controller has four states. ST_IDLE moves to ST_STARTUP when a start is accepted. ST_STARTUP moves to ST_SAMPLE after 6 ticks. ST_SAMPLE moves to ST_CONVERT after L ticks. ST_CONVERT moves back to ST_SAMPLE after 25 ticks when more samples remain. It moves to ST_IDLE after 25 ticks on the last sample, and that transition raises done.

Top module: `adc_conv_seq`

## Requirements
- R1: While reset is asserted and after it is released, busy, both strobes and done are low and the result is zero; a reset in the middle of a run returns the block to this state.
- R2: The conversion tick occurs once every 1, 2, 4 or 8 system clocks for divider codes 0, 1, 2 and 3, and all phase lengths are counted in ticks.
- R3: From the clock edge that accepts start to the edge that raises done, exactly (6 + N*(25 + L)) * D system clocks elapse, where D is the divide factor.
- R4: The extension L comes from {long_smp, smp_ext}: long_smp=0 gives 3, 5, 7, 9 ticks for smp_ext 0..3; long_smp=1 gives 13, 17, 21, 25 ticks for smp_ext 0..3.
- R5: With avg_en=0 one sample is taken; with avg_en=1, avg_sel 0, 1, 2, 3 gives N = 4, 8, 16, 32.
- R6: sample_en is high for exactly L ticks and convert_en for exactly 25 ticks per sample. The two are never high together, neither is high during startup or while idle.
- R7: One raw value is taken from conv_data at the last tick of each convert window; the result is the sum of the N values shifted right by log2(N).
- R8: Resolution code 0 keeps the low 8 bits of the average, code 1 the low 10 bits, codes 2 and 3 all 12 bits; the upper bits read zero.
- R9: A start pulse during a run is ignored: the run keeps its timing and result and no second run follows.
- R10: done is high for one clock; result changes only in the cycle done is high and holds afterwards.
- R11: The settings are captured when start is accepted; changing the setting inputs during a run changes neither its timing nor its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| div_sel_i | input | 2 | Tick divider code: divide by 1, 2, 4, 8 |
| long_smp_i | input | 1 | Long sample extension enable |
| smp_ext_i | input | 2 | Sample extension code |
| avg_en_i | input | 1 | Hardware averaging enable |
| avg_sel_i | input | 2 | Averaging count code: 4, 8, 16, 32 |
| res_mode_i | input | 2 | Resolution code: 8, 10, 12 bits |
| conv_data_i | input | DATA_W | Raw result from the converter stub |
| sample_en_o | output | 1 | Sample phase strobe |
| convert_en_o | output | 1 | Convert phase strobe |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | DATA_W | Averaged, right-justified result |

## Verification
The bench walks every extension code, every averaging count and every divider code. It counts system clocks from start to done and counts strobe-high cycles. A wrong extension table, a miscounted window or a tick off by one clock therefore shows up as a cycle count that misses the closed-form total. The stub returns a different value for each sample, so an accumulator that drops the last sample, shifts by the wrong amount or masks the wrong bits gives a wrong average. Separate runs inject a start pulse and a settings change mid-run. A design that restarts or that reads live settings would then finish early or late, or give a different result, and a reset in the middle of a run must clear a previously nonzero result.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STARTUP,
        ST_SAMPLE,
        ST_CONVERT
    } seq_state_e;

    typedef struct packed {
        logic [1:0] div_sel;
        logic       long_smp;
        logic [1:0] smp_ext;
        logic       avg_en;
        logic [1:0] avg_sel;
        logic [1:0] res_mode;
    } seq_cfg_t;

    // Sample extension in ticks for the combined {long, code} selector.
    function automatic logic [4:0] ext_ticks(input logic long_smp, input logic [1:0] code);
        logic [4:0] t;
        unique case ({long_smp, code})
            3'b000:  t = 5'd3;
            3'b001:  t = 5'd5;
            3'b010:  t = 5'd7;
            3'b011:  t = 5'd9;
            3'b100:  t = 5'd13;
            3'b101:  t = 5'd17;
            3'b110:  t = 5'd21;
            default: t = 5'd25;
        endcase
        return t;
    endfunction

    // log2 of the number of averaged samples.
    function automatic logic [2:0] avg_shift(input logic en, input logic [1:0] sel);
        return en ? (3'd2 + {1'b0, sel}) : 3'd0;
    endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             run_i,
    input  logic [SEL_W-1:0] div_sel_i,
    output logic             tick_o
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    always_comb begin
        mask   = ~({CNT_W{1'b1}} << div_sel_i);
        tick_o = run_i && ((cnt_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i || !run_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/adc_phase_fsm.sv
module adc_phase_fsm
    import adc_seq_pkg::*;
#(
    parameter int STARTUP_TICKS = 6,
    parameter int BASE_TICKS    = 25,
    parameter int PH_W          = 5,
    parameter int SMP_W         = 6,
    parameter int SH_W          = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            tick_i,
    input  logic [PH_W-1:0] ext_ticks_i,
    input  logic [SH_W-1:0] avg_shift_i,
    output logic            accept_o,
    output logic            busy_o,
    output logic            sample_en_o,
    output logic            convert_en_o,
    output logic            capture_o,
    output logic            finish_o
);
    seq_state_e        state_q, state_d;
    logic [PH_W-1:0]   pcnt_q;
    logic [SMP_W-1:0]  scnt_q;
    logic              ph_last;
    logic              smp_last;
    logic [SMP_W-1:0]  smp_target;

    always_comb begin
        smp_target = ~({SMP_W{1'b1}} << avg_shift_i);
        smp_last   = (scnt_q == smp_target);
        unique case (state_q)
            ST_STARTUP: ph_last = (pcnt_q == PH_W'(STARTUP_TICKS - 1));
            ST_SAMPLE:  ph_last = (pcnt_q == ext_ticks_i - PH_W'(1));
            ST_CONVERT: ph_last = (pcnt_q == PH_W'(BASE_TICKS - 1));
            default:    ph_last = 1'b0;
        endcase
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i)           state_d = ST_STARTUP;
            ST_STARTUP: if (tick_i && ph_last) state_d = ST_SAMPLE;
            ST_SAMPLE:  if (tick_i && ph_last) state_d = ST_CONVERT;
            ST_CONVERT: if (tick_i && ph_last) state_d = smp_last ? ST_IDLE : ST_SAMPLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // State register and phase / sample counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pcnt_q  <= '0;
            scnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                pcnt_q <= '0;
            end else if (tick_i && state_q != ST_IDLE) begin
                pcnt_q <= pcnt_q + 1'b1;
            end
            if (state_q == ST_IDLE) begin
                scnt_q <= '0;
            end else if (capture_o) begin
                scnt_q <= scnt_q + 1'b1;
            end
        end
    end

    // Outputs.
    always_comb begin
        accept_o     = start_i && (state_q == ST_IDLE);
        busy_o       = (state_q != ST_IDLE);
        sample_en_o  = (state_q == ST_SAMPLE);
        convert_en_o = (state_q == ST_CONVERT);
        capture_o    = (state_q == ST_CONVERT) && tick_i && ph_last;
        finish_o     = capture_o && smp_last;
    end

endmodule

// File: rtl/adc_avg_acc.sv
module adc_avg_acc #(
    parameter int DATA_W = 12,
    parameter int SH_W   = 3,
    parameter int MAX_SH = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              capture_i,
    input  logic              finish_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [SH_W-1:0]   shift_i,
    input  logic [1:0]        res_i,
    output logic [DATA_W-1:0] result_o,
    output logic              done_o
);
    localparam int ACC_W    = DATA_W + MAX_SH;
    localparam int DROP_LOW = DATA_W - 8;
    localparam int DROP_MID = DATA_W - 10;

    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  sum_next;
    logic [ACC_W-1:0]  shifted;
    logic [DATA_W-1:0] res_mask;

    always_comb begin
        sum_next = acc_q + ACC_W'(data_i);
        shifted  = sum_next >> shift_i;
        unique case (res_i)
            2'd0:    res_mask = {DATA_W{1'b1}} >> DROP_LOW;
            2'd1:    res_mask = {DATA_W{1'b1}} >> DROP_MID;
            default: res_mask = {DATA_W{1'b1}};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            result_o <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= finish_i;
            if (clear_i) begin
                acc_q <= '0;
            end else if (capture_i) begin
                acc_q <= sum_next;
            end
            if (finish_i) begin
                result_o <= shifted[DATA_W-1:0] & res_mask;
            end
        end
    end

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int DATA_W        = 12,
    parameter int STARTUP_TICKS = 6,
    parameter int BASE_TICKS    = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        div_sel_i,
    input  logic              long_smp_i,
    input  logic [1:0]        smp_ext_i,
    input  logic              avg_en_i,
    input  logic [1:0]        avg_sel_i,
    input  logic [1:0]        res_mode_i,
    input  logic [DATA_W-1:0] conv_data_i,
    output logic              sample_en_o,
    output logic              convert_en_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] result_o
);
    localparam int MAX_EXT  = 25;
    localparam int MAX_SH   = 5;
    localparam int SH_W     = 3;
    localparam int SMP_W    = MAX_SH + 1;
    localparam int PH_MAX   = (BASE_TICKS > MAX_EXT)
                              ? ((BASE_TICKS > STARTUP_TICKS) ? BASE_TICKS : STARTUP_TICKS)
                              : ((MAX_EXT > STARTUP_TICKS) ? MAX_EXT : STARTUP_TICKS);
    localparam int PH_W     = $clog2(PH_MAX + 1);

    seq_cfg_t        cfg_q;
    logic            accept;
    logic            conv_tick;
    logic            capture;
    logic            finish;
    logic [PH_W-1:0] ext_len;
    logic [SH_W-1:0] shift;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (accept) begin
            cfg_q <= '{div_sel:  div_sel_i,
                       long_smp: long_smp_i,
                       smp_ext:  smp_ext_i,
                       avg_en:   avg_en_i,
                       avg_sel:  avg_sel_i,
                       res_mode: res_mode_i};
        end
    end

    always_comb begin
        ext_len = PH_W'(ext_ticks(cfg_q.long_smp, cfg_q.smp_ext));
        shift   = avg_shift(cfg_q.avg_en, cfg_q.avg_sel);
    end

    adc_clk_div #(
        .SEL_W (2)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (accept),
        .run_i     (busy_o),
        .div_sel_i (cfg_q.div_sel),
        .tick_o    (conv_tick)
    );

    adc_phase_fsm #(
        .STARTUP_TICKS (STARTUP_TICKS),
        .BASE_TICKS    (BASE_TICKS),
        .PH_W          (PH_W),
        .SMP_W         (SMP_W),
        .SH_W          (SH_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .tick_i       (conv_tick),
        .ext_ticks_i  (ext_len),
        .avg_shift_i  (shift),
        .accept_o     (accept),
        .busy_o       (busy_o),
        .sample_en_o  (sample_en_o),
        .convert_en_o (convert_en_o),
        .capture_o    (capture),
        .finish_o     (finish)
    );

    adc_avg_acc #(
        .DATA_W (DATA_W),
        .SH_W   (SH_W),
        .MAX_SH (MAX_SH)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (accept),
        .capture_i (capture),
        .finish_i  (finish),
        .data_i    (conv_data_i),
        .shift_i   (shift),
        .res_i     (cfg_q.res_mode),
        .result_o  (result_o),
        .done_o    (done_o)
    );

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
    parameter int DATA_W     = 12,
    parameter int BASE_TICKS = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              tick_i,
    input logic              busy_o,
    input logic              sample_en_o,
    input logic              convert_en_o,
    input logic              done_o,
    input logic [DATA_W-1:0] result_o
);
    logic [5:0] cnv_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnv_ticks <= '0;
        end else if (!convert_en_o) begin
            cnv_ticks <= '0;
        end else if (tick_i) begin
            cnv_ticks <= cnv_ticks + 1'b1;
        end
    end

    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_en_o && convert_en_o));

    p_strobe_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en_o || convert_en_o) |-> busy_o);

    p_convert_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(convert_en_o) |-> (cnv_ticks == 6'(BASE_TICKS)));

    p_done_ends_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $fell(busy_o));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

endmodule

bind adc_conv_seq adc_seq_checker #(
    .DATA_W     (DATA_W),
    .BASE_TICKS (BASE_TICKS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .tick_i       (conv_tick),
    .busy_o       (busy_o),
    .sample_en_o  (sample_en_o),
    .convert_en_o (convert_en_o),
    .done_o       (done_o),
    .result_o     (result_o)
);

// File: tb/tb_adc_conv_seq.sv
`timescale 1ns/1ps
module tb_adc_conv_seq;
    localparam int DW     = 12;
    localparam int WD_CYC = 150000;

    typedef struct packed {
        logic [1:0]  div;
        logic        ls;
        logic [1:0]  st;
        logic        aen;
        logic [1:0]  asel;
        logic [1:0]  res;
        logic [11:0] base;
        logic [11:0] step;
        logic [15:0] cyc;
    } vec_t;

    // div, long, ext, avg_en, avg_sel, res, first raw, raw step, clocks start->done
    localparam vec_t VECS [0:8] = '{
        '{2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 2'd2, 12'hABC, 12'd0,   16'd34},
        '{2'd1, 1'b0, 2'd1, 1'b1, 2'd0, 2'd2, 12'd100, 12'd10,  16'd252},
        '{2'd2, 1'b0, 2'd2, 1'b1, 2'd1, 2'd1, 12'hFF0, 12'd1,   16'd1048},
        '{2'd3, 1'b0, 2'd3, 1'b0, 2'd0, 2'd0, 12'h1A5, 12'd0,   16'd320},
        '{2'd0, 1'b1, 2'd0, 1'b1, 2'd2, 2'd2, 12'd0,   12'd256, 16'd614},
        '{2'd1, 1'b1, 2'd1, 1'b1, 2'd3, 2'd2, 12'hFFF, 12'd0,   16'd2700},
        '{2'd0, 1'b1, 2'd2, 1'b0, 2'd0, 2'd1, 12'h7FF, 12'd0,   16'd52},
        '{2'd2, 1'b1, 2'd3, 1'b1, 2'd0, 2'd0, 12'd10,  12'd3,   16'd824},
        '{2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 2'd3, 12'hFFF, 12'd0,   16'd34}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    div_sel = '0;
    logic          long_smp = 1'b0;
    logic [1:0]    smp_ext = '0;
    logic          avg_en = 1'b0;
    logic [1:0]    avg_sel = '0;
    logic [1:0]    res_mode = '0;
    logic [DW-1:0] conv_data = '0;
    logic          sample_en, convert_en, busy, done;
    logic [DW-1:0] result;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    adc_conv_seq dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .div_sel_i    (div_sel),
        .long_smp_i   (long_smp),
        .smp_ext_i    (smp_ext),
        .avg_en_i     (avg_en),
        .avg_sel_i    (avg_sel),
        .res_mode_i   (res_mode),
        .conv_data_i  (conv_data),
        .sample_en_o  (sample_en),
        .convert_en_o (convert_en),
        .busy_o       (busy),
        .done_o       (done),
        .result_o     (result)
    );

    function automatic int ext_len(input logic ls, input logic [1:0] st);
        int tbl [8] = '{3, 5, 7, 9, 13, 17, 21, 25};
        return tbl[{ls, st}];
    endfunction

    function automatic int avg_n(input logic aen, input logic [1:0] asel);
        return aen ? (4 << asel) : 1;
    endfunction

    function automatic int div_f(input logic [1:0] d);
        return 1 << d;
    endfunction

    function automatic int exp_res(input vec_t v);
        int n, sh, sum, avg, bits;
        n   = avg_n(v.aen, v.asel);
        sh  = (n == 1) ? 0 : (n == 4) ? 2 : (n == 8) ? 3 : (n == 16) ? 4 : 5;
        sum = 0;
        for (int k = 0; k < n; k++) sum += (int'(v.base) + k * int'(v.step)) & 'hFFF;
        avg  = (sum >> sh) & 'hFFF;
        bits = (v.res == 2'd0) ? 8 : (v.res == 2'd1) ? 10 : 12;
        return avg & ((1 << bits) - 1);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        div_sel  = v.div;
        long_smp = v.ls;
        smp_ext  = v.st;
        avg_en   = v.aen;
        avg_sel  = v.asel;
        res_mode = v.res;
    endtask

    task automatic run(input vec_t v, input string pre, input int inj_at,
                       input bit inj_start, input vec_t alt);
        int cyc, smp_cnt, cnv_cnt, idx, n, l, d;
        bit seen, prev_cnv;
        logic [DW-1:0] keep;
        @(negedge clk);
        apply(v);
        conv_data = v.base;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0; smp_cnt = 0; cnv_cnt = 0; idx = 0; seen = 1'b0; prev_cnv = 1'b0;
        while (!seen && cyc < 20000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (cyc == inj_at) begin
                apply(alt);
                start = inj_start;
            end else begin
                start = 1'b0;
            end
            if (sample_en) smp_cnt++;
            if (convert_en) cnv_cnt++;
            if (prev_cnv && !convert_en) begin
                idx++;
                conv_data = DW'(int'(v.base) + idx * int'(v.step));
            end
            prev_cnv = convert_en;
            if (done) seen = 1'b1;
        end
        n = avg_n(v.aen, v.asel);
        l = ext_len(v.ls, v.st);
        d = div_f(v.div);
        chk({pre, "R3 R2 R4 R5 clocks start to done"}, cyc, int'(v.cyc));
        chk({pre, "R6 sample strobe clocks"}, smp_cnt, n * l * d);
        chk({pre, "R6 convert strobe clocks"}, cnv_cnt, n * 25 * d);
        chk({pre, "R7 R8 result"}, int'(result), exp_res(v));
        keep = result;
        @(posedge clk);
        @(negedge clk);
        chk({pre, "R10 done one cycle"}, int'(done), 0);
        chk({pre, "R10 result held"}, int'(result), int'(keep));
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", WD_CYC);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int dcount;
        repeat (4) @(negedge clk);
        chk("R1 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 sample strobe after reset", int'(sample_en), 0);
        chk("R1 convert strobe after reset", int'(convert_en), 0);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 result after reset", int'(result), 0);

        // Table walk.
        for (int i = 0; i < 9; i++) begin
            run(VECS[i], "", -1, 1'b0, VECS[i]);
            repeat (2) @(negedge clk);
        end

        // R9: start pulse mid-run carrying other settings.
        run(VECS[1], "R9 ", 100, 1'b1, VECS[6]);
        dcount = 0;
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if (done || busy) dcount++;
        end
        chk("R9 no second run after ignored start", dcount, 0);

        // R11: settings inputs change mid-run without a start.
        run(VECS[7], "R11 ", 300, 1'b0, VECS[3]);
        repeat (2) @(negedge clk);

        // R1: reset in the middle of a run clears a nonzero result.
        chk("R1 result nonzero before reset", int'(result != 0), 1);
        apply(VECS[5]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 busy after mid-run reset", int'(busy), 0);
        chk("R1 strobes after mid-run reset", int'(sample_en | convert_en), 0);
        chk("R1 result after mid-run reset", int'(result), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run(VECS[0], "R1 ", -1, 1'b0, VECS[0]);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule